// File: doc/BRIEF.md
# Partial-Fill Direct-Mapped Instruction Cache

This block sits in a 32-bit instruction fetch path. A fetch unit presents a word address with a request strobe. The cache answers with the 32-bit instruction word and a one-cycle response strobe. Lines are selected directly from the middle address bits.

On a miss, the block reads a simple synchronous backing port one word per cycle. A fill does not always load a whole line. It starts at the word that missed and stops at the last word of the line. The full missed word address is then kept as the line's tag. A later access to a lower word in that line compares below the tag, so it misses and refills from that lower word.

An invalidate input empties every line in a single cycle. If a fetch arrives in the same cycle as an invalidate, the fetch is treated as a miss.

Top module: `fetch_icache`

## Requirements
- R1: After a miss, `rvalid_o` presents exactly the backing word held at the requested address.
- R2: A hit is answered in the cycle after acceptance with the cached word. It makes no backing read, and `ready_o` stays high.
- R3: The line index is address bits [11:4] and the word offset is bits [3:2]. A hit needs bits [31:4] of the address to equal those of the stored tag. Two addresses that share an index but differ above bit 11 evict each other.
- R4: An access whose word address is lower than the stored tag's word address misses, even when bits [31:4] match.
- R5: A miss at word offset k reads backing words k through 3 in ascending address order, one per cycle. The first read is issued in the cycle after acceptance. `ready_o` is low until the response. `rvalid_o` is high in the cycle that follows the (5-k)th rising edge after the acceptance edge.
- R6: Once a fill at offset k completes, accesses to offsets k through 3 of that line hit.
- R7: Pulsing `inv_i` for one cycle empties every line. Every later fetch misses until that line is refilled.
- R8: A request accepted while `inv_i` is high is a miss, even if the line held the address.
- R9: Lines with different indices hold their contents independently.
- R10: After reset, `ready_o` is 1, `rvalid_o` and `mem_req_o` are 0, and all lines are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Fetch request, taken when ready_o is high |
| addr_i | input | 32 | Fetch byte address (bits [1:0] ignored) |
| inv_i | input | 1 | Invalidate every line |
| ready_o | output | 1 | Cache idle and able to take a request |
| rvalid_o | output | 1 | Response strobe for rdata_o |
| rdata_o | output | 32 | Fetched instruction word |
| mem_req_o | output | 1 | Backing read strobe |
| mem_addr_o | output | 32 | Backing read byte address |
| mem_rdata_i | input | 32 | Backing data, valid the cycle after mem_req_o |

## Verification
The hardest situation to reach is a line that holds only its upper words, followed by an access to a lower word of that same line. Here the tag bits match, yet the access must miss. The bench reaches it by first missing at word 2 of a fresh line. It then hits word 3 and fetches word 0. It checks the latency and the number of backing reads each time, which shows whether a partial or a full fill took place. Invalidate priority is reached by raising the request and `inv_i` together on a line known to be resident.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_FILL,
    FS_DRAIN
  } fill_st_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int LINES = 256,
  parameter int WPL   = 4,
  parameter int WA_W  = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inv_i,
  input  logic [WA_W-1:0] look_wa_i,
  output logic            hit_o,
  input  logic            set_i,
  input  logic [WA_W-1:0] set_wa_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WPL);

  logic [WA_W-1:0]  tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [IDX_W-1:0] look_idx, set_idx;
  logic [WA_W-1:0]  cur;

  assign look_idx = look_wa_i[OFF_W +: IDX_W];
  assign set_idx  = set_wa_i[OFF_W +: IDX_W];

  always_ff @(posedge clk_i) begin
    if (set_i) tag_q[set_idx] <= set_wa_i;
  end

  // set after clear: a fill finishing under invalidate keeps its line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (inv_i) vld_q <= '0;
      if (set_i) vld_q[set_idx] <= 1'b1;
    end
  end

  // tag holds the missed word address; lower words of the line are absent
  always_comb begin
    cur   = tag_q[look_idx];
    hit_o = vld_q[look_idx] && !inv_i &&
            (cur[WA_W-1:OFF_W] == look_wa_i[WA_W-1:OFF_W]) &&
            (look_wa_i >= cur);
  end

  assert_inv_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inv_i) && !$past(set_i) |-> vld_q == '0);
endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int LINES  = 256,
  parameter int WPL    = 4,
  parameter int DATA_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 we_i,
  input  logic [$clog2(LINES*WPL)-1:0]         waddr_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  input  logic [$clog2(LINES*WPL)-1:0]         raddr_i,
  output logic [DATA_W-1:0]                    rdata_o
);
  logic [DATA_W-1:0] mem_q [LINES*WPL];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/icache_fill.sv
module icache_fill
  import icache_pkg::*;
#(
  parameter int LINES  = 256,
  parameter int WPL    = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LSB_W  = 2,
  localparam int WA_W  = ADDR_W - LSB_W,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WPL)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [WA_W-1:0]        req_wa_i,
  input  logic                   hit_i,
  input  logic [DATA_W-1:0]      hit_data_i,
  output logic                   ready_o,
  output logic                   rvalid_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   wr_en_o,
  output logic [IDX_W+OFF_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0]      wr_data_o,
  output logic                   set_o,
  output logic [WA_W-1:0]        set_wa_o
);
  localparam logic [OFF_W-1:0]  LAST = OFF_W'(WPL - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << LSB_W;

  fill_st_e          st_q;
  logic [WA_W-1:0]   miss_wa_q;
  logic [OFF_W-1:0]  cnt_q, pend_off_q;
  logic              pend_v_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, last_wr;

  assign ready_o    = (st_q == FS_IDLE);
  assign accept     = ready_o && req_i;
  assign mem_req_o  = (st_q == FS_FILL);
  assign mem_addr_o = {miss_wa_q[WA_W-1:OFF_W], cnt_q, {LSB_W{1'b0}}};
  assign wr_en_o    = pend_v_q;
  assign wr_addr_o  = {miss_wa_q[OFF_W +: IDX_W], pend_off_q};
  assign wr_data_o  = mem_rdata_i;
  assign last_wr    = pend_v_q && (pend_off_q == LAST);
  assign set_o      = last_wr;
  assign set_wa_o   = miss_wa_q;
  assign rvalid_o   = rvalid_q;
  assign rdata_o    = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= FS_IDLE;
      miss_wa_q  <= '0;
      cnt_q      <= '0;
      pend_off_q <= '0;
      pend_v_q   <= 1'b0;
      rvalid_q   <= 1'b0;
      rdata_q    <= '0;
    end else begin
      pend_v_q <= 1'b0;
      rvalid_q <= last_wr;
      if (pend_v_q && (pend_off_q == miss_wa_q[OFF_W-1:0])) rdata_q <= mem_rdata_i;
      unique case (st_q)
        FS_IDLE: begin
          if (accept && hit_i) begin
            rvalid_q <= 1'b1;
            rdata_q  <= hit_data_i;
          end else if (accept) begin
            st_q      <= FS_FILL;
            miss_wa_q <= req_wa_i;
            cnt_q     <= req_wa_i[OFF_W-1:0];
          end
        end
        FS_FILL: begin
          pend_v_q   <= 1'b1;
          pend_off_q <= cnt_q;
          cnt_q      <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= FS_DRAIN;
        end
        FS_DRAIN: st_q <= FS_IDLE;
        default:  st_q <= FS_IDLE;
      endcase
    end
  end

  assert_miss_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !hit_i |=> mem_req_o && (mem_addr_o[ADDR_W-1:LSB_W] == $past(req_wa_i)));
  assert_fill_seq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + STEP);
  assert_hit_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && hit_i |=> rvalid_o && !mem_req_o);
  assert_rvalid_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && ready_o && hit_i) || $past(st_q == FS_DRAIN));
endmodule

// File: rtl/fetch_icache.sv
module fetch_icache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WPL    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inv_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int LSB_W = $clog2(DATA_W / 8);
  localparam int WA_W  = ADDR_W - LSB_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WPL);

  logic [WA_W-1:0]        look_wa, set_wa;
  logic                   hit, set, wr_en;
  logic [DATA_W-1:0]      hit_data, wr_data;
  logic [IDX_W+OFF_W-1:0] wr_addr;

  assign look_wa = addr_i[ADDR_W-1:LSB_W];

  icache_tags #(.LINES(LINES), .WPL(WPL), .WA_W(WA_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inv_i     (inv_i),
    .look_wa_i (look_wa),
    .hit_o     (hit),
    .set_i     (set),
    .set_wa_i  (set_wa)
  );

  icache_data #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (look_wa[IDX_W+OFF_W-1:0]),
    .rdata_o (hit_data)
  );

  icache_fill #(
    .LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LSB_W(LSB_W)
  ) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_wa_i    (look_wa),
    .hit_i       (hit),
    .hit_data_i  (hit_data),
    .ready_o     (ready_o),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .set_o       (set),
    .set_wa_o    (set_wa)
  );
endmodule

// File: tb/fetch_icache_bench.sv
`timescale 1ns/1ps
module fetch_icache_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        inv_i = 1'b0;
  logic        ready_o, rvalid_o, mem_req_o;
  logic [31:0] rdata_o, mem_addr_o;
  logic [31:0] mem_rdata_i = '0;

  int          n_chk = 0;
  int          n_fail = 0;
  int          nreads = 0;
  logic [31:0] first_addr = '0;
  logic        req_d = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_icache u_fetch_icache (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .inv_i(inv_i),
    .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_0F96;
  endfunction

  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata_i <= model(mem_addr_o);
      nreads      <= nreads + 1;
      if (!req_d) first_addr <= mem_addr_o;
    end
    req_d <= mem_req_o;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one request; checks data, latency in cycles and backing reads
  task automatic fetch(input logic [31:0] a, input bit with_inv, input int exp_lat,
                       input int exp_reads, input string rq);
    int base, lat;
    @(negedge clk);
    base = nreads; req_i = 1'b1; addr_i = a; inv_i = with_inv;
    @(negedge clk);
    req_i = 1'b0; inv_i = 1'b0; lat = 1;
    while (!rvalid_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(rdata_o == model(a), rq, rdata_o, model(a));
    chk(lat == exp_lat, rq, lat, exp_lat);
    chk(nreads - base == exp_reads, rq, nreads - base, exp_reads);
    if (exp_reads > 0) chk(first_addr == a, rq, first_addr, a);
  endtask

  task automatic t_reset;
    chk(ready_o == 1'b1, "R10 ready", ready_o, 1);
    chk(rvalid_o == 1'b0, "R10 rvalid", rvalid_o, 0);
    chk(mem_req_o == 1'b0, "R10 mem_req", mem_req_o, 0);
    fetch(32'h0000_1230, 0, 6, 4, "R10 R1 R5 cold miss");
  endtask

  task automatic t_hit;
    fetch(32'h0000_1230, 0, 1, 0, "R2 hit word0");
    fetch(32'h0000_123C, 0, 1, 0, "R2 hit word3");
  endtask

  task automatic t_partial;
    fetch(32'h0000_4568, 0, 4, 2, "R5 miss offset2");
    fetch(32'h0000_456C, 0, 1, 0, "R6 hit above");
    fetch(32'h0000_4560, 0, 6, 4, "R4 below tag miss");
    fetch(32'h0000_4568, 0, 1, 0, "R6 hit after refill");
    fetch(32'h0000_777C, 0, 3, 1, "R5 miss offset3");
  endtask

  task automatic t_alias;
    fetch(32'h0001_1230, 0, 6, 4, "R3 upper differs");
    fetch(32'h0000_1230, 0, 6, 4, "R3 evicted back");
  endtask

  task automatic t_index;
    fetch(32'h0000_1240, 0, 6, 4, "R9 other index");
    fetch(32'h0000_1234, 0, 1, 0, "R9 first line kept");
    fetch(32'h0000_1248, 0, 1, 0, "R9 second line kept");
  endtask

  task automatic t_inv;
    @(negedge clk); inv_i = 1'b1;
    @(negedge clk); inv_i = 1'b0;
    fetch(32'h0000_1230, 0, 6, 4, "R7 miss after inv");
    fetch(32'h0000_1244, 0, 5, 3, "R7 second line emptied");
  endtask

  task automatic t_inv_req;
    fetch(32'h0000_1230, 1, 6, 4, "R8 inv with request");
    fetch(32'h0000_1230, 0, 1, 0, "R8 refilled line hits");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_partial();
    t_alias();
    t_index();
    t_inv();
    t_inv_req();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule